// File: doc/BRIEF.md
# Clause-45 MDIO Management Engine

This block lets a host reach the registers of clause-45 PHYs over a two-wire management bus. The host first loads a 32-bit data register and then writes a command word that names a 16-bit register address, a 5-bit device type, a 5-bit PHY port, an operation and a start bit. The engine sends an address frame on MDC/MDIO and then, for reads and writes, a second frame of the requested kind to the same port and device. When the last frame has ended it clears the start bit, which the host polls. Read results arrive in the upper half of the data register.

Only one host may drive the bus at a time. A small ownership lock decides which host requester may issue commands. The owner cannot release the lock while a command is in flight, so it stays held for the whole address-plus-data sequence. MDC is made from the system clock by a parameterised divider and is held low whenever no frame is running.

Top module: `mdio_c45_engine`

## Requirements
- R1: After reset, the command and data registers read zero, MDC is low, MDIO is not driven (mdio_oe low) and the lock is free.
- R2: The command word layout is: bit 30 busy/start, bits 27:26 operation (00 address only, 01 write, 11 read), bits 25:21 PHY port, bits 20:16 device type, bits 15:0 register address. A command write is accepted only if all of these hold: bit 30 is set, the operation is not 10, the engine is idle, and the lock is held by the writing requester. An accepted write shows busy in the cycle after the write. Any other command write leaves the command register unchanged and sends no frame.
- R3: Every accepted command first sends an address frame, most significant bit first, made of: 32 ones, start bits 00, opcode 00, port, device type, turnaround 10, and the 16-bit register address.
- R4: A write command then sends a frame with opcode 01 and the same port and device. It carries turnaround 10 and the data register's bits 15:0.
- R5: A read command then sends a frame with opcode 11 and the same port and device. MDIO is released from the first turnaround bit to the end of the frame. The 16 data bits are sampled on rising MDC edges and stored in data register bits 31:16, while bits 15:0 are kept.
- R6: A command with operation 00 sends only the address frame.
- R7: Busy clears when the last frame of the command ends. The other command fields keep the value that was written.
- R8: While busy, writes to the command register or to the data register have no effect.
- R9: A take request grants the lock to the requester only when the lock is free. A give request releases it only when made by the owner while the engine is idle. All other take and give requests are ignored.
- R10: While a frame runs, MDC stays high for CLK_DIV system clocks and low for CLK_DIV system clocks. A driven MDIO changes only while MDC is low, and MDC is low whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | One-cycle register write strobe |
| reg_sel | input | 1 | Write target: 0 data register, 1 command register |
| reg_wdata | input | 32 | Register write value |
| req_id | input | HID_W | Requester issuing the write, take or give |
| lock_take | input | 1 | Request to acquire the port lock |
| lock_give | input | 1 | Request to release the port lock |
| cmd_reg | output | 32 | Current command register, bit 30 busy |
| data_reg | output | 32 | Data register: read result 31:16, write data 15:0 |
| lock_held | output | 1 | Lock is owned |
| lock_owner | output | HID_W | Current lock owner |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
An accepted command shows busy one cycle after the write. The first MDC rise follows CLK_DIV cycles later, and each frame then takes 128·CLK_DIV cycles. Busy clears and read data lands on the same edge as the last falling MDC edge of the final frame. For that reason the bench checks busy on the falling clock edge right after a write, and checks frame contents and registers only after it has seen busy clear while polling on falling edges. A slave model captures every frame bit on rising MDC and answers reads on falling MDC. Writes that should be ignored are checked one cycle later through the registers, the lock outputs and the count of captured frames.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;
  typedef enum logic [1:0] {OP_ADDR = 2'b00, OP_WRITE = 2'b01, OP_BAD = 2'b10, OP_READ = 2'b11} mdio_op_e;
  typedef enum logic [2:0] {ST_IDLE, ST_ADDR_GO, ST_ADDR_RUN, ST_DATA_GO, ST_DATA_RUN} seq_state_e;

  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;
  localparam int CMD_BUSY   = 30;

  function automatic logic [63:0] build_frame(input logic [1:0] op, input logic [4:0] port,
                                              input logic [4:0] dev, input logic [15:0] payload);
    return {32'hFFFF_FFFF, 2'b00, op, port, dev, 2'b10, payload};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV = 25,
  localparam int CW = $clog2(DIV + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap      = en && (cnt == CW'(DIV - 1));
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R10: the management clock parks low once frames stop
  p_idle_mdc_low_r10: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !mdc);
endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift
  import mdio_c45_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] frame,
  input  logic        is_read,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        active,
  output logic        done,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rdata
);
  logic [63:0] sh;
  logic [5:0]  pos;
  logic        rd_mode;

  assign done    = active && fall_tick && (pos == 6'(FRAME_BITS - 1));
  assign mdio_o  = active ? sh[63] : 1'b1;
  assign mdio_oe = active && !(rd_mode && (pos >= 6'(TA_FIRST)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh      <= '0;
      pos     <= '0;
      active  <= 1'b0;
      rd_mode <= 1'b0;
      rdata   <= '0;
    end else if (!active) begin
      if (start) begin
        sh      <= frame;
        pos     <= '0;
        active  <= 1'b1;
        rd_mode <= is_read;
      end
    end else begin
      if (rise_tick && rd_mode && (pos >= 6'(DATA_FIRST)))
        rdata <= {rdata[14:0], mdio_i};
      if (fall_tick) begin
        if (pos == 6'(FRAME_BITS - 1)) begin
          active <= 1'b0;
        end else begin
          pos <= pos + 1'b1;
          sh  <= {sh[62:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_port_lock.sv
module mdio_port_lock #(
  parameter int HOSTS = 2,
  localparam int HID_W = (HOSTS > 1) ? $clog2(HOSTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             give,
  input  logic [HID_W-1:0] req_id,
  input  logic             in_use,
  output logic             held,
  output logic [HID_W-1:0] owner
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held  <= 1'b0;
      owner <= '0;
    end else if (take && !held) begin
      held  <= 1'b1;
      owner <= req_id;
    end else if (give && held && (owner == req_id) && !in_use) begin
      held <= 1'b0;
    end
  end

  // R9: a lock in use cannot be dropped or handed over
  p_owner_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    held && in_use |=> held && $stable(owner));
endmodule

// File: rtl/mdio_c45_engine.sv
module mdio_c45_engine
  import mdio_c45_pkg::*;
#(
  parameter int CLK_DIV = 25,
  parameter int HOSTS = 2,
  localparam int HID_W = (HOSTS > 1) ? $clog2(HOSTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [31:0]      reg_wdata,
  input  logic [HID_W-1:0] req_id,
  input  logic             lock_take,
  input  logic             lock_give,
  output logic [31:0]      cmd_reg,
  output logic [31:0]      data_reg,
  output logic             lock_held,
  output logic [HID_W-1:0] lock_owner,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  seq_state_e  state;
  logic [31:0] cmd_q, data_q;
  logic        accept, frame_go, is_read, active, done, rise_tick, fall_tick;
  logic [63:0] frame;
  logic [15:0] rdata;
  mdio_op_e    op;

  assign op       = mdio_op_e'(cmd_q[27:26]);
  assign accept   = reg_wr && reg_sel && (state == ST_IDLE) && reg_wdata[CMD_BUSY]
                 && (reg_wdata[27:26] != OP_BAD) && lock_held && (lock_owner == req_id);
  assign frame_go = (state == ST_ADDR_GO) || (state == ST_DATA_GO);
  assign is_read  = (state == ST_DATA_GO) && (op == OP_READ);

  always_comb begin
    if (state == ST_ADDR_GO)
      frame = build_frame(OP_ADDR, cmd_q[25:21], cmd_q[20:16], cmd_q[15:0]);
    else
      frame = build_frame(op, cmd_q[25:21], cmd_q[20:16], (op == OP_READ) ? 16'hFFFF : data_q[15:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            cmd_q <= {2'b01, 2'b00, reg_wdata[27:0]};
            state <= ST_ADDR_GO;
          end else if (reg_wr && !reg_sel) begin
            data_q <= reg_wdata;
          end
        end
        ST_ADDR_GO: state <= ST_ADDR_RUN;
        ST_ADDR_RUN: begin
          if (done) begin
            if (op == OP_ADDR) begin
              cmd_q[CMD_BUSY] <= 1'b0;
              state <= ST_IDLE;
            end else begin
              state <= ST_DATA_GO;
            end
          end
        end
        ST_DATA_GO: state <= ST_DATA_RUN;
        ST_DATA_RUN: begin
          if (done) begin
            if (op == OP_READ) data_q[31:16] <= rdata;
            cmd_q[CMD_BUSY] <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_reg  = cmd_q;
  assign data_reg = data_q;

  mdio_port_lock #(.HOSTS(HOSTS)) u_lock (
    .clk(clk), .rst_n(rst_n), .take(lock_take), .give(lock_give), .req_id(req_id),
    .in_use(cmd_q[CMD_BUSY]), .held(lock_held), .owner(lock_owner)
  );

  mdio_mdc_gen #(.DIV(CLK_DIV)) u_mdc (
    .clk(clk), .rst_n(rst_n), .en(active), .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_shift u_shift (
    .clk(clk), .rst_n(rst_n), .start(frame_go), .frame(frame), .is_read(is_read),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i), .active(active),
    .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rdata(rdata)
  );

  // R9: a running command always has the lock behind it
  p_busy_owned_r9: assert property (@(posedge clk) disable iff (!rst_n) cmd_q[CMD_BUSY] |-> lock_held);
  // R8: the command word does not move while busy
  p_cmd_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[CMD_BUSY] && $past(cmd_q[CMD_BUSY]) |-> $stable(cmd_q));
  // R5: the lower data half survives the whole command
  p_low_half_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[CMD_BUSY] && $past(cmd_q[CMD_BUSY]) |-> $stable(data_q[15:0]));
  // R10: a driven data line only moves with the clock low
  p_mdio_moves_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o)) |-> !mdc);
endmodule

// File: tb/mdio_c45_engine_tb.sv
module mdio_c45_engine_tb;
  localparam int DIV = 2;
  localparam int HOSTS = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0, lock_take = 1'b0, lock_give = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [0:0]  req_id = '0;
  logic [31:0] cmd_reg, data_reg;
  logic        lock_held, mdc, mdio_o, mdio_oe;
  logic [0:0]  lock_owner;
  logic        slv_drive = 1'b1;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mdio_c45_engine #(.CLK_DIV(DIV), .HOSTS(HOSTS)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .req_id(req_id), .lock_take(lock_take), .lock_give(lock_give), .cmd_reg(cmd_reg),
    .data_reg(data_reg), .lock_held(lock_held), .lock_owner(lock_owner), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(slv_drive)
  );

  // ---------------- slave model ----------------
  logic [63:0] frames [8];
  int          nfr = 0;
  int          bitc = 0;
  logic [63:0] fsh = '0;
  logic [1:0]  cur_op = 2'b00;
  logic [4:0]  cur_port = '0, cur_dev = '0;
  logic [15:0] last_addr = '0;

  function automatic logic [15:0] resp(input logic [4:0] p, input logic [4:0] d, input logic [15:0] a);
    return a ^ {p, d, 6'h15};
  endfunction

  always @(posedge mdc) begin
    fsh  = {fsh[62:0], (mdio_oe ? mdio_o : slv_drive)};
    bitc = bitc + 1;
    if (bitc == 36) cur_op = fsh[1:0];
    if (bitc == 41) cur_port = fsh[4:0];
    if (bitc == 46) cur_dev = fsh[4:0];
    if (bitc == 64) begin
      frames[nfr % 8] = fsh;
      nfr  = nfr + 1;
      bitc = 0;
      if (cur_op == 2'b00) last_addr = fsh[15:0];
    end
  end

  always @(negedge mdc) begin
    if (cur_op == 2'b11 && bitc >= 48 && bitc <= 63)
      slv_drive = resp(cur_port, cur_dev, last_addr)[63 - bitc];
    else if (cur_op == 2'b11 && bitc == 47)
      slv_drive = 1'b0;
    else
      slv_drive = 1'b1;
  end

  // ---------------- helpers ----------------
  function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] p,
                                            input logic [4:0] d, input logic [15:0] w);
    return {32'hFFFF_FFFF, 2'b00, op, p, d, 2'b10, w};
  endfunction

  function automatic logic [31:0] cmdw(input logic busy, input logic [1:0] op, input logic [4:0] p,
                                       input logic [4:0] d, input logic [15:0] a);
    return {1'b0, busy, 2'b00, op, p, d, a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [31:0] d, input logic [0:0] id);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d; req_id = id;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic lock_req(input logic tk, input logic [0:0] id);
    @(negedge clk);
    lock_take = tk; lock_give = !tk; req_id = id;
    @(negedge clk);
    lock_take = 1'b0; lock_give = 1'b0;
  endtask

  task automatic wait_idle(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!cmd_reg[30]) begin ok = 1'b1; return; end
    end
  endtask

  task automatic run_txn(input logic [1:0] op, input logic [4:0] p, input logic [4:0] d,
                         input logic [15:0] a, input logic [15:0] wd, input logic [0:0] host);
    int base;
    bit ok;
    logic [15:0] rd;
    rd = resp(p, d, a);
    reg_write(1'b0, {16'h1234, wd}, host);
    base = nfr;
    reg_write(1'b1, cmdw(1'b1, op, p, d, a), host);
    chk(cmd_reg == cmdw(1'b1, op, p, d, a), "R2 busy shown after accepted write", 64'(cmd_reg), 64'(cmdw(1'b1, op, p, d, a)));
    wait_idle(ok);
    chk(ok, "R7 busy clears", 64'(ok), 64'd1);
    chk((nfr - base) == ((op == 2'b00) ? 1 : 2), "R6 frame count", 64'(nfr - base), 64'((op == 2'b00) ? 1 : 2));
    chk(frames[base % 8] == exp_frame(2'b00, p, d, a), "R3 address frame", frames[base % 8], exp_frame(2'b00, p, d, a));
    if (op == 2'b01)
      chk(frames[(base + 1) % 8] == exp_frame(2'b01, p, d, wd), "R4 write frame",
          frames[(base + 1) % 8], exp_frame(2'b01, p, d, wd));
    if (op == 2'b11)
      chk(frames[(base + 1) % 8] == exp_frame(2'b11, p, d, rd), "R5 read frame",
          frames[(base + 1) % 8], exp_frame(2'b11, p, d, rd));
    chk(cmd_reg == cmdw(1'b0, op, p, d, a), "R7 fields kept", 64'(cmd_reg), 64'(cmdw(1'b0, op, p, d, a)));
    if (op == 2'b11)
      chk(data_reg == {rd, wd}, "R5 read data placement", 64'(data_reg), 64'({rd, wd}));
    else
      chk(data_reg == {16'h1234, wd}, "R4 data register kept", 64'(data_reg), 64'({16'h1234, wd}));
    chk(!mdc && !mdio_oe, "R10 idle bus", 64'({mdc, mdio_oe}), 64'd0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  logic [4:0] port_l [4] = '{5'd0, 5'd1, 5'd17, 5'd31};
  logic [4:0] dev_l  [4] = '{5'd0, 5'd7, 5'd30, 5'd31};

  initial begin
    int base;
    bit ok;
    int hi, lo;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_reg == 0 && data_reg == 0, "R1 registers zero", {cmd_reg, data_reg}, 64'd0);
    chk(!mdc && !mdio_oe && !lock_held, "R1 bus and lock idle", 64'({mdc, mdio_oe, lock_held}), 64'd0);

    // R2 start without lock ignored
    base = nfr;
    reg_write(1'b1, cmdw(1'b1, 2'b11, 5'd3, 5'd1, 16'h0042), 1'b0);
    chk(cmd_reg == 0, "R2 no lock no start", 64'(cmd_reg), 64'd0);
    repeat (300) @(negedge clk);
    chk(nfr == base, "R2 no frame without lock", 64'(nfr), 64'(base));

    // R9 lock rules
    lock_req(1'b1, 1'b1);
    chk(lock_held && lock_owner == 1'b1, "R9 take when free", 64'({lock_held, lock_owner}), 64'b11);
    lock_req(1'b1, 1'b0);
    chk(lock_held && lock_owner == 1'b1, "R9 take by other ignored", 64'({lock_held, lock_owner}), 64'b11);
    lock_req(1'b0, 1'b0);
    chk(lock_held && lock_owner == 1'b1, "R9 give by non-owner ignored", 64'({lock_held, lock_owner}), 64'b11);

    // R2 non-owner command ignored, bad op ignored, missing busy ignored
    reg_write(1'b1, cmdw(1'b1, 2'b01, 5'd2, 5'd2, 16'h1111), 1'b0);
    chk(cmd_reg == 0, "R2 non-owner command ignored", 64'(cmd_reg), 64'd0);
    reg_write(1'b1, cmdw(1'b1, 2'b10, 5'd2, 5'd2, 16'h1111), 1'b1);
    chk(cmd_reg == 0, "R2 operation 10 ignored", 64'(cmd_reg), 64'd0);
    reg_write(1'b1, cmdw(1'b0, 2'b01, 5'd2, 5'd2, 16'h1111), 1'b1);
    chk(cmd_reg == 0, "R2 missing start bit ignored", 64'(cmd_reg), 64'd0);

    // R6 address only
    run_txn(2'b00, 5'd9, 5'd4, 16'hC0DE, 16'h0F0F, 1'b1);

    // R10 MDC phase lengths
    reg_write(1'b1, cmdw(1'b1, 2'b00, 5'd1, 5'd1, 16'h0001), 1'b1);
    @(posedge mdc);
    hi = 0;
    while (mdc) begin @(negedge clk); if (mdc) hi++; end
    lo = 1;
    while (!mdc) begin @(negedge clk); if (!mdc) lo++; end
    chk(hi == DIV, "R10 MDC high time", 64'(hi), 64'(DIV));
    chk(lo == DIV, "R10 MDC low time", 64'(lo), 64'(DIV));
    wait_idle(ok);

    // R8 / R9 writes and release while busy
    begin
      logic [15:0] rd;
      rd = resp(5'd21, 5'd3, 16'h8001);
      reg_write(1'b0, 32'h0000_5A5A, 1'b1);
      base = nfr;
      reg_write(1'b1, cmdw(1'b1, 2'b11, 5'd21, 5'd3, 16'h8001), 1'b1);
      repeat (20) @(negedge clk);
      reg_write(1'b1, cmdw(1'b1, 2'b01, 5'd6, 5'd6, 16'h7777), 1'b1);
      chk(cmd_reg == cmdw(1'b1, 2'b11, 5'd21, 5'd3, 16'h8001), "R8 command write while busy ignored",
          64'(cmd_reg), 64'(cmdw(1'b1, 2'b11, 5'd21, 5'd3, 16'h8001)));
      reg_write(1'b0, 32'hFFFF_FFFF, 1'b1);
      chk(data_reg == 32'h0000_5A5A, "R8 data write while busy ignored", 64'(data_reg), 64'h5A5A);
      lock_req(1'b0, 1'b1);
      chk(lock_held && lock_owner == 1'b1, "R9 give while busy ignored", 64'({lock_held, lock_owner}), 64'b11);
      wait_idle(ok);
      chk(ok && nfr - base == 2, "R8 only the original command ran", 64'(nfr - base), 64'd2);
      chk(frames[(base + 1) % 8] == exp_frame(2'b11, 5'd21, 5'd3, rd), "R8 original read frame",
          frames[(base + 1) % 8], exp_frame(2'b11, 5'd21, 5'd3, rd));
      chk(data_reg == {rd, 16'h5A5A}, "R5 read result after intrusion", 64'(data_reg), 64'({rd, 16'h5A5A}));
    end

    // sweep of ports, devices and operations
    for (int pi = 0; pi < 4; pi++)
      for (int di = 0; di < 4; di++)
        for (int oi = 0; oi < 2; oi++) begin
          logic [15:0] a;
          a = 16'hA5C3 ^ 16'(pi * 2731 + di * 97 + oi * 5);
          run_txn(oi ? 2'b11 : 2'b01, port_l[pi], dev_l[di], a, ~a, 1'b1);
        end

    // R9 release by owner when idle, then a new owner
    lock_req(1'b0, 1'b1);
    chk(!lock_held, "R9 owner release when idle", 64'(lock_held), 64'd0);
    lock_req(1'b1, 1'b0);
    chk(lock_held && lock_owner == 1'b0, "R9 new owner", 64'({lock_held, lock_owner}), 64'b10);
    run_txn(2'b11, 5'd31, 5'd31, 16'hFFFF, 16'h0000, 1'b0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule